// File: doc/BRIEF.md
# Instruction-Boundary Exception Prioritizer

This block sits beside the retire stage of a simple in-order core and decides, each time an instruction completes, whether an exception is taken and which one. At every retire strobe it looks at three candidates. The first is a software trap or other synchronous exception raised by the retiring instruction itself. The second is a trace request, made when the trace-enable bit of the live status register was set while the instruction ran. The third is the pending interrupt level. The block takes at most one of them. When it does, it reports the kind, presents the status-register image that the stack writer must push, and updates the live status register for handler entry.

A return-from-exception strobe restores the live status register from the value popped off the stack. Instruction decode, the stack writes and the vector fetch stay outside the block. An interrupt that loses to a trace is not stored inside the block. It is sampled again at the next retire, which is the first instruction of the trace handler, so the handlers nest naturally.

Status-register layout used throughout: bit 15 is trace enable, bit 13 is supervisor, bits 10:8 are the interrupt mask. Exception kind encoding: 0 = none, 1 = trace, 2 = interrupt, 3 = trap.

Top module: `exc_boundary_arbiter`

## Requirements
- R1: While rst_n is low and after its release, the live status register (sr_o) reads 16'h2700 (supervisor bit 13 set, mask bits 10:8 = 7, trace bit 15 clear), take_o is 0 and kind_o is 0.
- R2: Exceptions are evaluated only on a cycle with retire_i high and rte_i low. The result is registered, so take_o and kind_o (0 none, 1 trace, 2 interrupt, 3 trap) are valid in the cycle after the strobe. At most one exception is taken per strobe, and take_o is 0 in every cycle that does not follow such a strobe.
- R3: A trace exception (kind 1) is requested for a retiring instruction only when bit 15 of the live status register is set at that retire.
- R4: When a trace and an acceptable interrupt are both present at one retire, the trace is taken and the interrupt is not.
- R5: When retire_trap_i is high at a retire, the trap (kind 3) is taken and no trace is produced, even with bit 15 set. The trap also wins over any pending interrupt.
- R6: An interrupt (kind 2) is accepted only when irq_level_i is greater than mask bits 10:8, or when irq_level_i is 7. Level 0 is never accepted.
- R7: On any taken exception, stacked_sr_o equals the live status register as it stood just before entry. The live register then has bit 15 cleared and bit 13 set.
- R8: On a taken interrupt, mask bits 10:8 of the live status register become the accepted level.
- R9: rte_i loads the live status register from rte_sr_i. A retire in the same cycle is ignored. The next retire is evaluated with the restored trace bit and mask.
- R10: An interrupt that lost to a trace is taken at the next retire (the first handler instruction) if it is still pending and is above the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | An instruction completes this cycle |
| retire_trap_i | input | 1 | The retiring instruction raised a trap or other synchronous exception |
| irq_level_i | input | 3 | Pending interrupt level, 0 = none |
| rte_i | input | 1 | Return-from-exception: restore the status register |
| rte_sr_i | input | 16 | Status-register value popped from the stack |
| take_o | output | 1 | An exception is taken (one cycle) |
| kind_o | output | 2 | Exception kind: 0 none, 1 trace, 2 interrupt, 3 trap |
| stacked_sr_o | output | 16 | Status-register image to push on entry |
| sr_o | output | 16 | Live status register |

## Verification
A wrong live status register shows up one cycle after the strobe that corrupted it, on sr_o. Its effect also shows at the next retire: a stray trace bit produces an unexpected kind 1, and a wrong mask accepts or blocks an interrupt it should not. A wrong priority choice, or a trace not suppressed on a trap, is visible on kind_o in the cycle right after the retire. The scoreboard compares take_o, kind_o, sr_o and, on entry, stacked_sr_o after every strobe, including those that should produce nothing.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_TRACE = 2'd1,
    EXC_IRQ   = 2'd2,
    EXC_TRAP  = 2'd3
  } exc_kind_e;

  localparam int SR_W      = 16;
  localparam int LVL_W     = 3;
  localparam int TRACE_BIT = 15;
  localparam int SUPV_BIT  = 13;
  localparam int MASK_LSB  = 8;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;

endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             accept_o
);
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

  logic above_mask;
  logic non_maskable;

  always_comb begin
    above_mask   = (level_i > mask_i);
    non_maskable = (level_i == LVL_TOP);
    accept_o     = above_mask | non_maskable;
  end
endmodule

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
(
  input  logic      eval_i,
  input  logic      trap_i,
  input  logic      trace_en_i,
  input  logic      irq_ok_i,
  output exc_kind_e kind_o
);
  always_comb begin
    kind_o = EXC_NONE;
    if (eval_i) begin
      if (trap_i)          kind_o = EXC_TRAP;
      else if (trace_en_i) kind_o = EXC_TRACE;
      else if (irq_ok_i)   kind_o = EXC_IRQ;
    end
  end
endmodule

// File: rtl/exc_sr_next.sv
module exc_sr_next
  import exc_pkg::*;
#(
  parameter int SR_W      = 16,
  parameter int LVL_W     = 3,
  parameter int TRACE_BIT = 15,
  parameter int SUPV_BIT  = 13,
  parameter int MASK_LSB  = 8
) (
  input  logic [SR_W-1:0]  sr_i,
  input  exc_kind_e        kind_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             rte_i,
  input  logic [SR_W-1:0]  rte_sr_i,
  output logic [SR_W-1:0]  sr_o
);
  localparam int MASK_MSB = MASK_LSB + LVL_W - 1;

  always_comb begin
    sr_o = sr_i;
    if (rte_i) begin
      sr_o = rte_sr_i;
    end else if (kind_i != EXC_NONE) begin
      sr_o[TRACE_BIT] = 1'b0;
      sr_o[SUPV_BIT]  = 1'b1;
      if (kind_i == EXC_IRQ) sr_o[MASK_MSB:MASK_LSB] = level_i;
    end
  end
endmodule

// File: rtl/exc_boundary_arbiter.sv
module exc_boundary_arbiter
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             retire_trap_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic             rte_i,
  input  logic [SR_W-1:0]  rte_sr_i,
  output logic             take_o,
  output logic [1:0]       kind_o,
  output logic [SR_W-1:0]  stacked_sr_o,
  output logic [SR_W-1:0]  sr_o
);
  localparam int MASK_MSB = MASK_LSB + LVL_W - 1;

  logic [SR_W-1:0] sr_q, sr_d;
  logic [SR_W-1:0] stk_q;
  logic            take_q, take_d;
  exc_kind_e       kind_q, kind_d;
  logic            eval;
  logic            irq_ok;
  logic            sr_en;

  assign eval = retire_i & ~rte_i;

  exc_irq_gate #(.LVL_W(LVL_W)) u_gate (
    .level_i  (irq_level_i),
    .mask_i   (sr_q[MASK_MSB:MASK_LSB]),
    .accept_o (irq_ok)
  );

  exc_select u_sel (
    .eval_i     (eval),
    .trap_i     (retire_trap_i),
    .trace_en_i (sr_q[TRACE_BIT]),
    .irq_ok_i   (irq_ok),
    .kind_o     (kind_d)
  );

  exc_sr_next #(
    .SR_W(SR_W), .LVL_W(LVL_W), .TRACE_BIT(TRACE_BIT),
    .SUPV_BIT(SUPV_BIT), .MASK_LSB(MASK_LSB)
  ) u_srn (
    .sr_i     (sr_q),
    .kind_i   (kind_d),
    .level_i  (irq_level_i),
    .rte_i    (rte_i),
    .rte_sr_i (rte_sr_i),
    .sr_o     (sr_d)
  );

  always_comb begin
    take_d = (kind_d != EXC_NONE);
    sr_en  = rte_i | take_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= SR_RESET;
      take_q <= 1'b0;
      kind_q <= EXC_NONE;
      stk_q  <= '0;
    end else begin
      take_q <= take_d;
      kind_q <= kind_d;
      if (sr_en)  sr_q  <= sr_d;
      if (take_d) stk_q <= sr_q;
    end
  end

  assign take_o       = take_q;
  assign kind_o       = kind_q;
  assign stacked_sr_o = stk_q;
  assign sr_o         = sr_q;

  // R2
  no_take_without_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(retire_i && !rte_i));

  // R7
  entry_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (!sr_q[TRACE_BIT] && sr_q[SUPV_BIT]));

  // R7
  stack_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (stk_q == $past(sr_q)));

  // R5
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retire_i && retire_trap_i && !rte_i) |-> (take_q && kind_q == EXC_TRAP));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && kind_q == EXC_IRQ) |-> (sr_q[MASK_MSB:MASK_LSB] == $past(irq_level_i)));

  // R9
  rte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rte_i) |-> (sr_q == $past(rte_sr_i) && !take_q));
endmodule

// File: tb/exc_boundary_arbiter_tb.sv
`timescale 1ns/1ps
module exc_boundary_arbiter_tb;
  typedef struct {
    logic        take;
    logic [1:0]  kind;
    logic [15:0] stk;
    logic [15:0] sr;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_i = 1'b0, retire_trap_i = 1'b0, rte_i = 1'b0;
  logic [2:0]  irq_level_i = 3'd0;
  logic [15:0] rte_sr_i = 16'h0;
  logic        take_o;
  logic [1:0]  kind_o;
  logic [15:0] stacked_sr_o, sr_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  logic [15:0] msr;

  always #2 clk = ~clk;

  exc_boundary_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .retire_trap_i(retire_trap_i),
    .irq_level_i(irq_level_i), .rte_i(rte_i), .rte_sr_i(rte_sr_i),
    .take_o(take_o), .kind_o(kind_o), .stacked_sr_o(stacked_sr_o), .sr_o(sr_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic rt, input logic tp, input logic [2:0] lv,
                      input logic rv, input logic [15:0] rs, input string req);
    item_t it;
    logic  ok_irq;
    @(negedge clk);
    retire_i = rt; retire_trap_i = tp; irq_level_i = lv; rte_i = rv; rte_sr_i = rs;
    it.take = 1'b0; it.kind = 2'd0; it.stk = 16'h0; it.req = req;
    if (rv) begin
      msr = rs;
    end else if (rt) begin
      ok_irq = (lv == 3'd7) || (lv > msr[10:8]);
      if (tp)           it.kind = 2'd3;
      else if (msr[15]) it.kind = 2'd1;
      else if (ok_irq)  it.kind = 2'd2;
      if (it.kind != 2'd0) begin
        it.take = 1'b1;
        it.stk  = msr;
        msr[15] = 1'b0;
        msr[13] = 1'b1;
        if (it.kind == 2'd2) msr[10:8] = lv;
      end
    end
    it.sr = msr;
    exp_q.push_back(it);
  endtask

  // monitor: compares after each edge that follows a driven cycle
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      chk(take_o == e.take, e.req, "take", {15'd0, take_o}, {15'd0, e.take});
      chk(kind_o == e.kind, e.req, "kind", {14'd0, kind_o}, {14'd0, e.kind});
      chk(sr_o == e.sr, e.req, "sr", sr_o, e.sr);
      if (e.take) chk(stacked_sr_o == e.stk, e.req, "stacked", stacked_sr_o, e.stk);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    msr = 16'h2700;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(sr_o == 16'h2700, "R1", "sr in reset", sr_o, 16'h2700);
    chk(!take_o && kind_o == 2'd0, "R1", "take/kind in reset", {14'd0, kind_o}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(sr_o == 16'h2700 && !take_o, "R1", "after release", sr_o, 16'h2700);

    // R2: no retire, pending NMI -> nothing taken
    step(0, 0, 3'd7, 0, 16'h0, "R2_idle");
    // R6: mask 7 blocks level 5
    step(1, 0, 3'd5, 0, 16'h0, "R6_masked");
    // R6: level 7 passes mask 7
    step(1, 0, 3'd7, 0, 16'h0, "R6_nmi");
    // R9: restore to user mode with trace on, mask 0
    step(0, 0, 3'd0, 1, 16'h8000, "R9_rte");
    // R3/R4: trace and interrupt together -> trace
    step(1, 0, 3'd3, 0, 16'h0, "R4_trace_first");
    // R10: first handler instruction -> nested interrupt, R8 mask = 3
    step(1, 0, 3'd3, 0, 16'h0, "R10_nested_irq");
    // R6: level equal to mask -> none
    step(1, 0, 3'd3, 0, 16'h0, "R6_equal_mask");
    // R3: trace off -> none with level 0
    step(1, 0, 3'd0, 0, 16'h0, "R3_no_trace");
    // R9: retire in same cycle as rte is ignored
    step(1, 1, 3'd7, 1, 16'h8000, "R9_rte_wins");
    // R5: trap with trace on and interrupt pending -> trap only
    step(1, 1, 3'd5, 0, 16'h0, "R5_trap");
    // R9: return from trap, next instruction traced
    step(0, 0, 3'd0, 1, 16'h8200, "R9_rte_trap");
    step(1, 0, 3'd1, 0, 16'h0, "R3_trace_after_rte");
    // R6: level 4 above mask 2 in user mode without trace
    step(0, 0, 3'd0, 1, 16'h0200, "R9_rte_user");
    step(1, 0, 3'd4, 0, 16'h0, "R6_above_mask");
    step(0, 0, 3'd0, 0, 16'h0, "R2_tail");
    @(posedge clk); #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule